// File: doc/BRIEF.md
# Vector Register Group Element Mapper

This block finds where one element of a logical vector sits in a 32-entry vector register file. A logical vector can occupy a group of 1, 2, 4 or 8 consecutive architectural registers. Elements are packed in ascending order: the first register of the group fills completely before the next one is used. The caller supplies the group base register, the group multiplier, the element width, the element index and the active vector length. The block returns the physical register, the byte offset inside that register, and a byte-enable over the register's bytes. It also flags illegal accesses and tail elements.

An execute or load/store stage uses the mapper to steer each element's write into the register file. Any access that is illegal or lies in the tail gets an all-zero byte-enable, so it never changes register contents. Register width is the parameter `VLEN`, a power of two of at least 32 bits. The result is registered and appears one clock after the inputs.

Top module: `vgrp_mapper`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Encodings are fixed. lmul_i values 0,1,2,3 select a group of 1,2,4,8 registers. sew_i values 0,1,2,3 select an element width of 8,16,32,64 bits. vreg_o equals base_i plus idx_i divided by (VLEN / element width), modulo 32. With VLEN=128 and 8-bit elements, indices 0..15 map to base_i and indices 16..31 map to base_i+1.
- R3: byte_off_o equals (idx_i modulo (VLEN / element width)) multiplied by the element width in bytes.
- R4: For a legal, non-tail element, byte_en_o has exactly element-width/8 contiguous ones, starting at bit byte_off_o. Bit k of byte_en_o enables byte k of the register.
- R5: When base_i is not a multiple of the group size, illegal_o is 1 and byte_en_o is zero.
- R6: When idx_i is at or beyond the group capacity (group size × VLEN / element width), illegal_o is 1 and byte_en_o is zero. Such an access would otherwise reach a register outside the group.
- R7: When the element width exceeds VLEN, illegal_o is 1 and byte_en_o is zero.
- R8: When idx_i ≥ vl_i, tail_o is 1 and byte_en_o is zero. tail_o is computed independently of illegal_o.
- R9: All outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 5 | Group base register number |
| lmul_i | input | 2 | Group multiplier code (0..3 → 1,2,4,8) |
| sew_i | input | 2 | Element width code (0..3 → 8,16,32,64 bits) |
| idx_i | input | IDX_W | Logical element index |
| vl_i | input | IDX_W | Active vector length in elements |
| vreg_o | output | 5 | Physical register holding the element |
| byte_off_o | output | log2(VLEN/8) | Byte offset of the element in the register |
| byte_en_o | output | VLEN/8 | Per-byte write enable |
| illegal_o | output | 1 | Misaligned base, index beyond the group, or element wider than the register |
| tail_o | output | 1 | Element index at or above the vector length |

## Verification
The stimulus uses 8-bit elements with indices on both sides of each register boundary, to show that elements stripe across registers rather than interleave. It also uses 64-bit elements, where a few indices already cross registers, and confirms the offset scales with element width. Misaligned bases are driven at every group size, and indices are driven at the group capacity and one below it, to separate the alignment check from the capacity check. Random mixes of vector length against index show that the tail flag does not depend on legality. A second instance with VLEN=32 exercises the case of an element wider than the register.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
  localparam int unsigned NUM_VREG = 32;
  localparam int unsigned VREG_W   = $clog2(NUM_VREG);

  typedef enum logic [1:0] {GRP_1, GRP_2, GRP_4, GRP_8} grp_e;
  typedef enum logic [1:0] {EW_8, EW_16, EW_32, EW_64} ew_e;

  function automatic int unsigned ew_bytes(ew_e ew);
    return 32'd1 << ew;
  endfunction

  function automatic int unsigned grp_regs(grp_e g);
    return 32'd1 << g;
  endfunction
endpackage

// File: rtl/vgrp_legal.sv
module vgrp_legal
  import vgrp_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned IDX_W = 16
) (
  input  logic [VREG_W-1:0] base_i,
  input  grp_e              grp_i,
  input  ew_e               ew_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  vl_i,
  input  logic              within_i,
  output logic              ew_big_o,
  output logic              legal_o,
  output logic              tail_o
);
  logic aligned;

  always_comb begin
    aligned  = (int'(base_i) % int'(grp_regs(grp_i))) == 0;
    ew_big_o = (ew_bytes(ew_i) * 8) > VLEN;
    legal_o  = aligned && !ew_big_o && within_i;
    tail_o   = idx_i >= vl_i;
  end
endmodule

// File: rtl/vgrp_locate.sv
module vgrp_locate
  import vgrp_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned IDX_W = 16,
  localparam int unsigned VLENB     = VLEN / 8,
  localparam int unsigned VLENB_LOG = $clog2(VLENB),
  localparam int unsigned OFF_W     = VLENB_LOG
) (
  input  logic [VREG_W-1:0] base_i,
  input  grp_e              grp_i,
  input  ew_e               ew_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ew_big_i,
  output logic [VREG_W-1:0] vreg_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              within_o
);
  int unsigned      shamt;
  logic [IDX_W-1:0] reg_step;
  logic [IDX_W-1:0] lane;
  logic [IDX_W-1:0] off_full;

  always_comb begin
    // elements per register = 2**shamt
    shamt    = ew_big_i ? 0 : VLENB_LOG - int'(ew_i);
    reg_step = idx_i >> shamt;
    vreg_o   = base_i + reg_step[VREG_W-1:0];
    within_o = (reg_step >> grp_i) == '0;
    lane     = idx_i & ((IDX_W'(1) << shamt) - IDX_W'(1));
    off_full = lane << ew_i;
    off_o    = off_full[OFF_W-1:0];
  end
endmodule

// File: rtl/vgrp_lanes.sv
module vgrp_lanes
  import vgrp_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLENB = VLEN / 8,
  localparam int unsigned OFF_W = $clog2(VLENB)
) (
  input  logic             en_i,
  input  ew_e              ew_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [VLENB-1:0] be_o
);
  int unsigned nbytes;

  always_comb begin
    nbytes = ew_bytes(ew_i);
    for (int unsigned k = 0; k < VLENB; k++) begin
      be_o[k] = en_i && (k >= int'(off_i)) && (k < int'(off_i) + nbytes);
    end
  end
endmodule

// File: rtl/vgrp_mapper.sv
module vgrp_mapper
  import vgrp_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned IDX_W = 16,
  localparam int unsigned VLENB = VLEN / 8,
  localparam int unsigned OFF_W = $clog2(VLENB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        base_i,
  input  logic [1:0]        lmul_i,
  input  logic [1:0]        sew_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  vl_i,
  output logic [4:0]        vreg_o,
  output logic [OFF_W-1:0]  byte_off_o,
  output logic [VLENB-1:0]  byte_en_o,
  output logic              illegal_o,
  output logic              tail_o
);
  grp_e              grp;
  ew_e               ew;
  logic              ew_big_c, legal_c, tail_c, within_c;
  logic [VREG_W-1:0] vreg_c;
  logic [OFF_W-1:0]  off_c;
  logic [VLENB-1:0]  be_c;

  assign grp = grp_e'(lmul_i);
  assign ew  = ew_e'(sew_i);

  vgrp_legal #(.VLEN(VLEN), .IDX_W(IDX_W)) i_legal (
    .base_i(base_i), .grp_i(grp), .ew_i(ew), .idx_i(idx_i), .vl_i(vl_i),
    .within_i(within_c), .ew_big_o(ew_big_c), .legal_o(legal_c), .tail_o(tail_c)
  );

  vgrp_locate #(.VLEN(VLEN), .IDX_W(IDX_W)) i_locate (
    .base_i(base_i), .grp_i(grp), .ew_i(ew), .idx_i(idx_i), .ew_big_i(ew_big_c),
    .vreg_o(vreg_c), .off_o(off_c), .within_o(within_c)
  );

  vgrp_lanes #(.VLEN(VLEN)) i_lanes (
    .en_i(legal_c && !tail_c), .ew_i(ew), .off_i(off_c), .be_o(be_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vreg_o     <= '0;
      byte_off_o <= '0;
      byte_en_o  <= '0;
      illegal_o  <= 1'b0;
      tail_o     <= 1'b0;
    end else begin
      vreg_o     <= vreg_c;
      byte_off_o <= off_c;
      byte_en_o  <= be_c;
      illegal_o  <= !legal_c;
      tail_o     <= tail_c;
    end
  end

  a_r5_illegal_no_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_c |-> be_c == '0);
  a_r4_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_c && !tail_c) |-> $countones(be_c) == (1 << sew_i));
  a_r6_stay_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_c |-> (vreg_c >> lmul_i) == (base_i >> lmul_i));
  a_r8_tail_no_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_c |-> be_c == '0);
  a_r9_out_enable_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en_o != '0) |-> (!illegal_o && !tail_o));
endmodule

// File: tb/test_vgrp_mapper.sv
module test_vgrp_mapper;
  localparam int PERIOD = 10;
  localparam int VLEN   = 128;
  localparam int VLENB  = VLEN / 8;
  localparam int IDX_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] base;
  logic [1:0] lmul, sew;
  logic [IDX_W-1:0] idx, vl;
  logic [4:0] vreg;
  logic [3:0] boff;
  logic [VLENB-1:0] be;
  logic ill, tl;
  logic [4:0] s_vreg;
  logic [1:0] s_boff;
  logic [3:0] s_be;
  logic s_ill, s_tl;

  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  vgrp_mapper #(.VLEN(VLEN), .IDX_W(IDX_W)) i_vgrp_mapper (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .lmul_i(lmul), .sew_i(sew),
    .idx_i(idx), .vl_i(vl), .vreg_o(vreg), .byte_off_o(boff), .byte_en_o(be),
    .illegal_o(ill), .tail_o(tl)
  );

  vgrp_mapper #(.VLEN(32), .IDX_W(IDX_W)) i_vgrp_mapper_small (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .lmul_i(lmul), .sew_i(sew),
    .idx_i(idx), .vl_i(vl), .vreg_o(s_vreg), .byte_off_o(s_boff), .byte_en_o(s_be),
    .illegal_o(s_ill), .tail_o(s_tl)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (base=%0d lmul=%0d sew=%0d idx=%0d vl=%0d)",
               req, act, exp, base, lmul, sew, idx, vl);
    end
  endtask

  // expected model for register width vlen
  task automatic expect_map(int vlen, int b, int lm, int sw, int ix, int vln,
                            output int e_reg, output int e_off, output longint e_be,
                            output int e_ill, output int e_tl, output int big);
    int nb, epr;
    nb  = 1 << sw;
    big = (nb * 8 > vlen);
    epr = big ? 1 : vlen / (nb * 8);
    e_reg = (b + ix / epr) % 32;
    e_off = (ix % epr) * nb;
    e_ill = (b % (1 << lm) != 0) || big || (ix >= (1 << lm) * epr);
    e_tl  = (ix >= vln);
    e_be  = (e_ill || e_tl) ? 0 : (((longint'(1) << nb) - 1) << e_off);
  endtask

  task automatic run(int b, int lm, int sw, int ix, int vln, string tag);
    int r, o, il, t, big;
    longint e;
    @(negedge clk);
    base = 5'(b); lmul = 2'(lm); sew = 2'(sw); idx = IDX_W'(ix); vl = IDX_W'(vln);
    @(negedge clk);
    expect_map(VLEN, b, lm, sw, ix, vln, r, o, e, il, t, big);
    if (!big) begin
      chk({tag, " R2 vreg"}, vreg, r);
      chk({tag, " R3 offset"}, boff, o);
    end
    chk({tag, " R4 byte_en"}, be, e);
    chk({tag, " R5/R6 illegal"}, ill, il);
    chk({tag, " R8 tail"}, tl, t);
    expect_map(32, b, lm, sw, ix, vln, r, o, e, il, t, big);
    chk({tag, " R7 small illegal"}, s_ill, il);
    chk({tag, " R7 small byte_en"}, s_be, e);
    if (!big) chk({tag, " R2 small vreg"}, s_vreg, r);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    base = 5'd3; lmul = 2'd0; sew = 2'd0; idx = 16'd5; vl = 16'd9;
    repeat (3) @(negedge clk);
    chk("R1 reset vreg", vreg, 0);
    chk("R1 reset byte_en", be, 0);
    chk("R1 reset flags", {ill, tl}, 0);
    rst_n = 1'b1;
    // R2 striping across register boundary, 8-bit elements
    run(8, 3, 0, 15, 200, "dir");
    run(8, 3, 0, 16, 200, "dir");
    run(8, 3, 0, 127, 200, "dir");
    // R6 capacity edge
    run(8, 3, 0, 128, 200, "dir");
    run(4, 1, 3, 3, 200, "dir");
    run(4, 1, 3, 4, 200, "dir");
    // R3 64-bit offsets
    run(0, 0, 3, 1, 2, "dir");
    // R5 misaligned at each group size
    run(1, 1, 0, 0, 9, "dir");
    run(2, 2, 1, 0, 9, "dir");
    run(4, 3, 2, 0, 9, "dir");
    run(31, 0, 0, 3, 9, "dir");
    // R8 tail alone and with illegal
    run(0, 0, 1, 5, 5, "dir");
    run(3, 1, 1, 5, 5, "dir");
    run(0, 0, 1, 4, 0, "dir");
    // R7 element wider than a 32-bit register
    run(0, 0, 3, 0, 4, "dir");
    run(0, 1, 2, 1, 4, "dir");
    // R9 one-cycle latency: change inputs, check old result still held before edge
    @(negedge clk);
    base = 5'd16; lmul = 2'd0; sew = 2'd0; idx = 16'd20; vl = 16'd40;
    @(negedge clk);
    base = 5'd0; idx = 16'd0;
    #1 chk("R9 latency vreg", vreg, 17);
    @(negedge clk);
    chk("R9 latency next", vreg, 0);
    for (int n = 0; n < 400; n++) begin
      int lm, b;
      lm = int'($urandom % 4);
      b  = int'($urandom % 32);
      if ($urandom % 4 != 0) b = b & ~((1 << lm) - 1);
      run(b, lm, int'($urandom % 4), int'($urandom % 1100), int'($urandom % 1100), "rnd");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule